// File: doc/BRIEF.md
# Paged Serial Configuration Bitstream Reader

This block is the read side of a serial configuration store. It sends a stored bitstream to a programmable-logic device one bit per configuration clock. An array of 16-bit words is walked by a word address counter and a bit counter, most significant bit first. When chip select is low and the combined reset/output-enable input is high, each clock moves the read position on by one bit. The data output is driven only while reading.

The array can be used as one flat range. It can also be used as four equal quarters, one of which is chosen by a 2-bit page code. The chosen range is captured when a reset occurs. The cascade output goes low once the last bit of the active range is reached, so that the next store in a daisy chain can take over. A synchronous load port fills the array.

Top module: `cfg_bitstream_reader`

## Requirements
- R1: With `ser_en` high, a clock edge that samples `rst_oe` low sets the read position to bit 15 of the first word of the range and captures the range from `page_en`/`page_sel`.
- R2: With `page_en` high at reset, the range is quarter `page_sel` of the array (code 0 is the lowest-addressed quarter and code 3 the highest), from its first word to its last word.
- R3: With `page_en` low at reset, the range is the whole array, from word 0 to the top word.
- R4: Bits leave each word from bit 15 down to bit 0. After bit 0 the next word starts at bit 15.
- R5: The position advances on a clock edge only when `ser_en` is high, `cs_n` is low and `rst_oe` is high. With `cs_n` high it holds.
- R6: `dout_oe` is high exactly when `ser_en` is high, `cs_n` is low and `rst_oe` is high. In that case `dout` carries the current bit; otherwise `dout` is 0.
- R7: Once bit 0 of the last word of the range is reached, further clocks hold that position until the next reset.
- R8: `casc_n` is low only while the end position is held, `cs_n` is low, `rst_oe` is high and `ser_en` is high. After a reset it stays high until the end is reached again.
- R9: Changes on `page_en`/`page_sel` outside a reset do not move the range or the read position.
- R10: With `ser_en` low, `rst_oe` low does not reset, the position does not advance, `dout_oe` is low and `casc_n` is high.
- R11: `load_en` high at a clock edge writes `load_data` into word `load_addr`, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| cs_n | input | 1 | Chip select, active low |
| rst_oe | input | 1 | Low: reset counters; high: enable output |
| page_en | input | 1 | Split the array into four quarters |
| page_sel | input | 2 | Quarter selection code |
| ser_en | input | 1 | Serial read mode enable (low = programming mode) |
| load_en | input | 1 | Array write strobe |
| load_addr | input | ADDR_W | Array write word address |
| load_data | input | WORD_W | Array write data |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Serial data driven (low = floating) |
| casc_n | output | 1 | Cascade output, active low at end of range |

## Verification
The hardest state to reach is the end of the range with chip select toggling and the output enable then being dropped. Getting there takes a full read of a range, which is hundreds of clocks of continuous selection. Random stimulus almost never gets that far, because it deselects and resets too often. The bench therefore reads a flat range and a quarter range to their ends in directed runs, toggles chip select and reset at the end position, and only then moves on to random mixed traffic. A reference model computed from the requirements is compared with the outputs on every cycle.

// File: rtl/cfg_bitstream_reader.sv
`timescale 1ns/1ps
module cfg_bitstream_reader #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              cs_n,
  input  logic              rst_oe,
  input  logic              page_en,
  input  logic [1:0]        page_sel,
  input  logic              ser_en,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              casc_n
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int PAGE_W = ADDR_W - 2;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] mem [WORDS];
  logic [ADDR_W-1:0] addr, base_q, last_q;
  logic [BIT_W-1:0]  bitc;

  wire reading   = ser_en & ~cs_n & rst_oe;
  wire reset_req = ser_en & ~rst_oe;
  wire at_end    = (addr == last_q) && (bitc == LAST_BIT);

  wire [ADDR_W-1:0] base_n = page_en ? {page_sel, {PAGE_W{1'b0}}} : '0;
  wire [ADDR_W-1:0] last_n = page_en ? {page_sel, {PAGE_W{1'b1}}} : '1;

  always_ff @(posedge clk)
    if (load_en) mem[load_addr] <= load_data;

  always_ff @(posedge clk) begin
    if (reset_req) begin
      base_q <= base_n;
      last_q <= last_n;
      addr   <= base_n;
      bitc   <= '0;
    end else if (reading && !at_end) begin
      if (bitc == LAST_BIT) begin
        bitc <= '0;
        addr <= addr + 1'b1;
      end else begin
        bitc <= bitc + 1'b1;
      end
    end
  end

  wire [WORD_W-1:0] rd_word = mem[addr];
  assign dout_oe = reading;
  assign dout    = reading & rd_word[LAST_BIT - bitc];
  assign casc_n  = ~(reading & at_end);

  p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_oe)
    1'b1 |-> (addr >= base_q) && (addr <= last_q));
  p_bit_step_r4: assert property (@(posedge clk) disable iff (!rst_oe)
    (reading && !at_end) |=> bitc == BIT_W'($past(bitc) + 1'b1));
  p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_oe)
    (reading && !at_end && bitc == LAST_BIT) |=> addr == $past(addr) + 1'b1);
  p_hold_deselected_r5: assert property (@(posedge clk) disable iff (!rst_oe)
    (ser_en && cs_n) |=> $stable(addr) && $stable(bitc));
  p_quiet_float_r6: assert property (@(posedge clk) disable iff (!rst_oe)
    !dout_oe |-> !dout);
  p_end_hold_r7: assert property (@(posedge clk) disable iff (!rst_oe)
    (reading && at_end) |=> $stable(addr) && $stable(bitc));
  p_casc_at_end_r8: assert property (@(posedge clk) disable iff (!rst_oe)
    !casc_n |-> (addr == last_q) && !cs_n);
  p_range_latched_r9: assert property (@(posedge clk) disable iff (!rst_oe)
    1'b1 |=> $stable(base_q) && $stable(last_q));
  p_prog_idle_r10: assert property (@(posedge clk) disable iff (!rst_oe)
    !ser_en |=> $stable(addr) && $stable(bitc));
endmodule

// File: tb/cfg_bitstream_reader_test.sv
`timescale 1ns/1ps
module cfg_bitstream_reader_test;
  localparam int ADDR_W = 6;
  localparam int WORDS  = 1 << ADDR_W;

  logic clk = 0, cs_n = 1, rst_oe = 0, page_en = 0, ser_en = 1, load_en = 0;
  logic [1:0] page_sel = 0;
  logic [ADDR_W-1:0] load_addr = 0;
  logic [15:0] load_data = 0;
  logic dout, dout_oe, casc_n;

  int checks = 0, errors = 0;
  logic [15:0] m_mem [WORDS];
  int m_addr = 0, m_bit = 0, m_base = 0, m_last = WORDS - 1;

  cfg_bitstream_reader #(.ADDR_W(ADDR_W), .WORD_W(16)) uut (
    .clk(clk), .cs_n(cs_n), .rst_oe(rst_oe), .page_en(page_en),
    .page_sel(page_sel), .ser_en(ser_en), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data),
    .dout(dout), .dout_oe(dout_oe), .casc_n(casc_n));

  always #10 clk = ~clk;

  function automatic bit m_reading();
    return ser_en && !cs_n && rst_oe;
  endfunction
  function automatic bit m_end();
    return m_addr == m_last && m_bit == 15;
  endfunction
  function automatic bit exp_dout();
    return m_reading() && m_mem[m_addr][15 - m_bit];
  endfunction
  function automatic bit exp_casc();
    return !(m_reading() && m_end());
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (load_en) m_mem[load_addr] = load_data;
    if (ser_en && !rst_oe) begin
      m_base = page_en ? page_sel * (WORDS / 4) : 0;
      m_last = page_en ? m_base + WORDS / 4 - 1 : WORDS - 1;
      m_addr = m_base;
      m_bit  = 0;
    end else if (m_reading() && !m_end()) begin
      if (m_bit == 15) begin m_bit = 0; m_addr++; end
      else m_bit++;
    end
    #5;
    check("R6 dout_oe", dout_oe, m_reading());
    check("R4 dout", dout, exp_dout());
    check("R8 casc_n", casc_n, exp_casc());
  endtask

  task automatic do_reset(input logic pe, input logic [1:0] ps);
    page_en = pe; page_sel = ps; rst_oe = 0; cs_n = 1;
    step();
    rst_oe = 1;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R11: fill the array through the load port
    for (int i = 0; i < WORDS; i++) begin
      load_en = 1; load_addr = ADDR_W'(i); load_data = 16'($urandom);
      step();
    end
    load_en = 0;

    // R1 R3: flat range reset, deselected output floats
    do_reset(0, 2'd0);
    check("R1 reset float oe", dout_oe, 1'b0);
    check("R1 reset casc high", casc_n, 1'b1);
    cs_n = 0; #1;
    check("R1 first bit is word0 bit15", dout, m_mem[0][15]);
    for (int i = 0; i < WORDS * 16 - 1; i++) step();
    check("R3 reached top word end casc low", casc_n, 1'b0);
    // R7: holds at final bit
    for (int i = 0; i < 5; i++) step();
    check("R7 final bit held", dout, m_mem[WORDS-1][0]);
    // R8: follows cs_n at end, then stays high after reset
    cs_n = 1; step();
    check("R8 casc follows cs_n high", casc_n, 1'b1);
    cs_n = 0; step();
    check("R8 casc follows cs_n low", casc_n, 1'b0);
    rst_oe = 0; #1;
    check("R8 casc high with rst_oe low", casc_n, 1'b1);

    // R2 R9: quarter 2, page inputs change mid read
    do_reset(1, 2'd2);
    cs_n = 0; #1;
    check("R2 quarter 2 first bit", dout, m_mem[2 * WORDS / 4][15]);
    for (int i = 0; i < 40; i++) step();
    page_sel = 2'd0; page_en = 0;
    // R5: deselect holds position
    cs_n = 1;
    for (int i = 0; i < 6; i++) step();
    cs_n = 0;
    for (int i = 0; i < (WORDS / 4) * 16 - 41; i++) step();
    check("R9 quarter end unaffected by page change", casc_n, 1'b0);
    check("R2 last bit of quarter 2", dout, m_mem[3 * WORDS / 4 - 1][0]);

    // R10: programming mode ignores reset and clock
    ser_en = 0; rst_oe = 0;
    for (int i = 0; i < 4; i++) step();
    check("R10 prog mode float", dout_oe, 1'b0);
    check("R10 prog mode casc high", casc_n, 1'b1);
    rst_oe = 1; ser_en = 1; #1;
    check("R10 no reset in prog mode", casc_n, 1'b0);

    // quarter 3 and quarter 0 short runs
    do_reset(1, 2'd3);
    cs_n = 0;
    for (int i = 0; i < (WORDS / 4) * 16 - 1; i++) step();
    check("R2 quarter 3 end", casc_n, 1'b0);
    do_reset(1, 2'd0);
    cs_n = 0; #1;
    check("R2 quarter 0 first bit", dout, m_mem[0][15]);

    // random mixed traffic
    for (int i = 0; i < 6000; i++) begin
      cs_n     = ($urandom_range(0, 9) < 2);
      rst_oe   = ($urandom_range(0, 199) != 0);
      ser_en   = ($urandom_range(0, 29) != 0);
      page_en  = 1'($urandom);
      page_sel = 2'($urandom);
      load_en  = ($urandom_range(0, 49) == 0);
      load_addr = ADDR_W'($urandom);
      load_data = 16'($urandom);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule